// File: doc/BRIEF.md
# Serial Gain-Word Receive Register

This block is the receiving end of a three-wire serial link that sets the gain code of a programmable attenuator. A host drives the enable line low, clocks in a gain word one bit per serial clock with the most significant bit first, and then drives enable high. The new code is then transferred to a held output latch that feeds the attenuator as a parallel gain code. While enable is low, the latch keeps the previous code, so the gain never moves in the middle of a load.

All three serial pins and the power-down pin are asynchronous to the local clock. The block samples them through synchronizers and rebuilds the master-slave behaviour in the local clock domain. A bit is taken on the serial clock's rising edge and moved into the shift stage on its falling edge. An active-low power-down input clears the output-enable flag at once, without waiting for a clock edge. The programmed gain is kept through power-down, and serial loads keep working while it is asserted. A flag reports whenever a load carried a bit count other than the word width, in which case the latch takes the last word-width bits that were shifted.

Top module: `sgw_rx`

## Requirements
- R1: While rst_n is low, gain_code is 0x00 (minimum gain), count_err is 0 and out_en is 0. A reset taken with ser_en low therefore leaves minimum gain in the latch.
- R2: After ser_en goes low, exactly 8 serial clocks and ser_en going high, gain_code equals the 8 bits sent, the first bit sent landing in bit 7 and the last in bit 0.
- R3: While ser_en is low, gain_code and count_err do not change.
- R4: Each bit is the ser_data value present at the ser_clk rising edge. A change of ser_data while ser_clk is high, before its falling edge, does not alter the bit.
- R5: ser_clk edges while ser_en is high do not move the shift register. A following load with no clocks returns the previous gain_code.
- R6: On each ser_en rising edge, count_err becomes 1 if the number of bits in that load differs from 8, and 0 if it is exactly 8. The latch receives the last 8 bits shifted, and earlier contents fill in when fewer than 8 bits were sent. Loads longer than 15 bits still report 1.
- R7: pd_n low forces out_en to 0 without any clk edge. After pd_n returns high, out_en becomes 1 on the second rising clk edge.
- R8: gain_code is kept across power-down, and a load completed while pd_n is low takes effect on gain_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_en | input | 1 | Load enable: low shifts in bits, high transfers and holds |
| pd_n | input | 1 | Asynchronous active-low power-down |
| gain_code | output | 8 | Latched gain code, 0 = minimum gain |
| out_en | output | 1 | Output path enabled (low during power-down) |
| count_err | output | 1 | Last load had a bit count other than 8 |

## Verification
The bench builds the block with its defaults: an 8-bit gain word and two synchronizer stages. The 4-bit saturating bit counter then makes a 16-bit load reachable, which must still report a count error, as must a load with no clocks at all. With two stages, the delay from a pin change to a latch update is short enough that every serial phase can hold for a few local clocks. Flipping ser_data inside each serial-clock high phase then separates rising-edge capture from falling-edge capture.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  parameter int unsigned GAIN_W_DEF = 8;
  parameter int unsigned SYNC_DEF   = 2;

  // counter wide enough to tell "more than a word" from "exactly a word"
  function automatic int unsigned cnt_width(input int unsigned w);
    return $clog2(2 * w);
  endfunction
endpackage

// File: rtl/sgw_sync.sv
module sgw_sync #(
  parameter int unsigned        W       = 3,
  parameter int unsigned        STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sgw_shift.sv
module sgw_shift #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          sdat_s,
  input  logic          en_s,
  output logic [W-1:0]  shreg,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          sclk_d, en_d, master;
  logic          master_n;
  logic [W-1:0]  shreg_n;
  logic [CW-1:0] cnt_n;
  logic          sclk_rise, sclk_fall, en_fall, load_win;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign en_fall   = ~en_s & en_d;
  assign load_win  = ~en_s;

  always_comb begin
    master_n = master;
    shreg_n  = shreg;
    cnt_n    = cnt;
    if (load_win && sclk_rise) master_n = sdat_s;
    if (load_win && sclk_fall) begin
      shreg_n = {shreg[W-2:0], master};
      if (cnt != CMAX) cnt_n = cnt + 1'b1;
    end
    if (en_fall) cnt_n = (load_win && sclk_fall) ? CW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      en_d   <= 1'b1;
      master <= 1'b0;
      shreg  <= '0;
      cnt    <= '0;
    end else begin
      sclk_d <= sclk_s;
      en_d   <= en_s;
      master <= master_n;
      shreg  <= shreg_n;
      cnt    <= cnt_n;
    end
  end
endmodule

// File: rtl/sgw_latch.sv
module sgw_latch #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_s,
  input  logic [W-1:0]  shreg,
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  gain,
  output logic          err
);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic         en_d;
  logic [W-1:0] gain_n;
  logic         err_n;

  always_comb begin
    gain_n = gain;
    err_n  = err;
    if (en_s)          gain_n = shreg;          // transparent while high
    if (en_s && !en_d) err_n  = (cnt != FULL);  // judged at the rising edge
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d <= 1'b1;
      gain <= '0;
      err  <= 1'b0;
    end else begin
      en_d <= en_s;
      gain <= gain_n;
      err  <= err_n;
    end
  end
endmodule

// File: rtl/sgw_pwr.sv
module sgw_pwr #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  output logic out_en
);
  logic             clr_n;
  logic [STAGES-1:0] chain;

  assign clr_n = rst_n & pd_n;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign out_en = chain[STAGES-1];
endmodule

// File: rtl/sgw_rx.sv
module sgw_rx #(
  parameter int unsigned GAIN_W      = sgw_pkg::GAIN_W_DEF,
  parameter int unsigned SYNC_STAGES = sgw_pkg::SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en,
  input  logic              pd_n,
  output logic [GAIN_W-1:0] gain_code,
  output logic              out_en,
  output logic              count_err
);
  localparam int unsigned CW = sgw_pkg::cnt_width(GAIN_W);

  logic [2:0]        pins_s;
  logic              en_s, sclk_s, sdat_s;
  logic [GAIN_W-1:0] shreg;
  logic [CW-1:0]     cnt;

  sgw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_en, ser_clk, ser_data}),
    .q(pins_s)
  );
  assign {en_s, sclk_s, sdat_s} = pins_s;

  sgw_shift #(.W(GAIN_W), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .sdat_s(sdat_s), .en_s(en_s),
    .shreg(shreg), .cnt(cnt)
  );

  sgw_latch #(.W(GAIN_W), .CW(CW)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .en_s(en_s), .shreg(shreg), .cnt(cnt),
    .gain(gain_code), .err(count_err)
  );

  sgw_pwr #(.STAGES(SYNC_STAGES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .out_en(out_en)
  );
endmodule

// File: rtl/sgw_rx_chk.sv
module sgw_rx_chk #(
  parameter int unsigned GAIN_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pd_n,
  input logic              out_en,
  input logic              count_err,
  input logic              en_s,
  input logic [GAIN_W-1:0] gain_code,
  input logic [GAIN_W-1:0] shreg
);
  // R1: reset values
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_state: assert (gain_code == '0 && !out_en && !count_err)
        else $error("reset state wrong");
    end
  end

  // R3: latch frozen while the synchronized enable was low
  a_r3_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_s) |-> $stable(gain_code));

  // R6: flag only moves on an enable rising edge
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_s) |-> $stable(count_err));

  // R5: shift register frozen while enable is high
  a_r5_shift_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_s) |-> $stable(shreg));

  // R7: power-down gates the output at once
  a_r7_pd_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> !out_en);

  // R7: output returns only after pd_n was seen high
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(pd_n));
endmodule

bind sgw_rx sgw_rx_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .out_en(out_en),
  .count_err(count_err), .en_s(en_s), .gain_code(gain_code), .shreg(shreg)
);

// File: tb/tb_sgw_rx.sv
module tb_sgw_rx;
  logic       clk = 1'b0;
  logic       rst_n, ser_clk, ser_data, ser_en, pd_n;
  logic [7:0] gain_code;
  logic       out_en, count_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sgw_rx dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en(ser_en), .pd_n(pd_n), .gain_code(gain_code),
    .out_en(out_en), .count_err(count_err)
  );

  // {bit count[4:0], bits[15:0] sent from bit count-1 down to 0, expected gain, expected flag}
  localparam logic [29:0] VEC [10] = '{
    {5'd8,  16'h00A5, 8'hA5, 1'b0},
    {5'd8,  16'h003C, 8'h3C, 1'b0},
    {5'd8,  16'h00FF, 8'hFF, 1'b0},
    {5'd8,  16'h0000, 8'h00, 1'b0},
    {5'd10, 16'h02C3, 8'hC3, 1'b1},
    {5'd3,  16'h0005, 8'h1D, 1'b1},
    {5'd0,  16'h0000, 8'h1D, 1'b1},
    {5'd8,  16'h0081, 8'h81, 1'b0},
    {5'd16, 16'hABCD, 8'hCD, 1'b1},
    {5'd8,  16'h0001, 8'h01, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // data flips while the serial clock is high: only rising-edge capture survives (R4)
  task automatic send_bit(input logic b);
    ser_data = b;  wclk(3);
    ser_clk  = 1'b1; wclk(4);
    ser_data = ~b; wclk(3);
    ser_clk  = 1'b0; wclk(4);
  endtask

  task automatic load(input int n, input logic [15:0] bits, input logic [7:0] prev,
                      input logic [7:0] exp, input logic experr);
    ser_en = 1'b0; wclk(4);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
    chk("R3 gain held while enable low", gain_code, prev);
    ser_en = 1'b1; wclk(5);
    chk("R2 R4 R6 gain after load", gain_code, exp);
    chk("R6 count flag", count_err, experr);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] prev;
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_en = 1'b0; pd_n = 1'b1;
    wclk(3);
    chk("R1 gain in reset", gain_code, 8'h00);
    chk("R1 out_en in reset", out_en, 1'b0);
    chk("R1 flag in reset", count_err, 1'b0);
    rst_n = 1'b1;
    wclk(4);
    chk("R7 out_en after reset release", out_en, 1'b1);
    chk("R1 minimum gain with enable held low", gain_code, 8'h00);

    prev = 8'h00;
    for (int v = 0; v < 10; v++) begin
      load(int'(VEC[v][29:25]), VEC[v][24:9], prev, VEC[v][8:1], VEC[v][0]);
      prev = VEC[v][8:1];
    end

    // R5: clocks with enable high are ignored
    for (int k = 0; k < 5; k++) send_bit(1'b1);
    chk("R5 gain after clocks with enable high", gain_code, 8'h01);
    load(0, 16'h0000, 8'h01, 8'h01, 1'b1);

    // R7: asynchronous power-down
    @(negedge clk);
    #2 pd_n = 1'b0;
    #1 chk("R7 out_en drops without clock edge", out_en, 1'b0);
    chk("R8 gain kept in power-down", gain_code, 8'h01);

    // R8: loading while powered down
    load(8, 16'h005A, 8'h01, 8'h5A, 1'b0);
    chk("R7 out_en still off", out_en, 1'b0);
    pd_n = 1'b1;
    wclk(1);
    chk("R7 out_en not yet back", out_en, 1'b0);
    wclk(2);
    chk("R7 out_en back after two edges", out_en, 1'b1);
    chk("R8 gain after power-up", gain_code, 8'h5A);

    // R1: reset during operation returns minimum gain
    rst_n = 1'b0;
    #1 chk("R1 gain cleared by reset", gain_code, 8'h00);
    chk("R1 out_en cleared by reset", out_en, 1'b0);
    wclk(2);
    rst_n = 1'b1;
    wclk(2);
    finish_up();
  end
endmodule